// File: doc/BRIEF.md
# Partial Reconfiguration Loader Front End

This block sits between a host's 32-bit register bus and the port that feeds a reconfigurable region. Software arms it by setting a start bit in a control/status word. It then writes the whole bitstream, word by word, to one fixed data address. The first data word is a header. It carries a 16-bit sync pattern in its upper half and the count of payload words in its lower half.

The block passes each payload word unchanged to a configuration sink over a valid/ready handshake. While the sink is busy, the block holds the bus. It XORs the payload words into a running value. The word after the last payload word is compared with that value.

Progress is shown in a three-bit status field. Software polls it until it reads success or one of three error codes. Writing zero to the start bit then returns the block to idle.

Top module: `prc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control/status word (byte offset 0x04) reads 0, and `snk_valid` is low.
- R2: Writing a 1 to bit 0 of the control/status word while the status is 0 makes bit 0 read 1 and the status field (bits [4:2]) read 4, meaning in progress.
- R3: Writing a 1 to bit 0 while the status is 4 has no effect: the status stays 4, bit 0 stays 1, and the frame in flight continues to its normal end.
- R4: If the first data word after arming does not hold 0xA5C3 in bits [31:16], the status becomes 3 and bit 0 clears. The header word is never passed to the sink.
- R5: Each payload word written to byte offset 0x00 appears on `snk_data`, unchanged and in order, for exactly one accepted handshake. This includes a trailing word that is zero-extended from one, two or three low bytes.
- R6: While a payload write is pending and `snk_ready` is low, `bus_ready` is low. The word is accepted once the sink becomes ready.
- R7: The header's bits [15:0] give the payload word count. If the data word that follows that many payload words equals the XOR of the payload words, the status becomes 5 and bit 0 clears.
- R8: If that check word differs from the XOR, the status becomes 2 and bit 0 clears.
- R9: A data write while the status is not 4 is accepted but not passed to the sink, and the status becomes 1.
- R10: Writing 0 to bit 0 when the status is 1, 2, 3 or 5 returns the status to 0. Writing 1 in those states leaves the status unchanged.
- R11: A header with a count of 0 is followed directly by the check word. A check word of 0 then gives status 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address: 0x00 data port, 0x04 control/status |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_ready | output | 1 | Request completes on this cycle's rising edge |
| bus_rdata | output | DATA_W (32) | Read data, valid while a read is ready |
| snk_valid | output | 1 | Payload word offered to the sink |
| snk_data | output | DATA_W (32) | Payload word |
| snk_ready | input | 1 | Sink can take a word |

## Verification
The bench targets the following corner cases:
- A sink that stalls for some cycles. A design that raised `bus_ready` regardless of the sink would lose words, and the scoreboard would find them missing.
- A second start request in the middle of a frame. A design that re-armed here would treat the next payload word as a header and fail the sync check.
- A header with a zero count, and a header whose sync pattern is wrong. If the header were forwarded, or the count were taken off by one, an extra word would reach the sink or the check word would be misplaced.
- Stray data writes while idle and after an error. A design that forwarded these, or kept the old status, is caught by the scoreboard and the status reads.

// File: rtl/prc_pkg.sv
// Shared encodings for the partial reconfiguration loader front end.
package prc_pkg;

    // Status field codes: software decodes these values, so they are fixed.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PRERR   = 3'd1,
        ST_SUMERR  = 3'd2,
        ST_BADHDR  = 3'd3,
        ST_BUSY    = 3'd4,
        ST_DONE    = 3'd5
    } prc_status_e;

    // Position inside the incoming frame.
    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,
        PH_HDR     = 2'd1,
        PH_PAYLOAD = 2'd2,
        PH_CHECK   = 2'd3
    } prc_phase_e;

    localparam int START_BIT   = 0;
    localparam int STATUS_LSB  = 2;
    localparam int STATUS_W    = 3;
    localparam int WORD_LSB    = 2;
    localparam int DATA_WORD   = 0;
    localparam int CSR_WORD    = 1;

endpackage

// File: rtl/prc_bus_decode.sv
// Address decode for the loader register bus.
// Assumes byte addresses and word-aligned registers; other words are
// accepted and ignored.
module prc_bus_decode #(
    parameter int ADDR_W = 4
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              data_wr,
    output logic              csr_wr,
    output logic              csr_rd
);
    import prc_pkg::*;

    localparam int IDX_W = ADDR_W - WORD_LSB;

    logic [IDX_W-1:0] word_idx;
    logic             hit_data;
    logic             hit_csr;
    logic             unused_low;

    // Select the word index and compare it with each register slot.
    always_comb begin
        word_idx   = bus_addr[ADDR_W-1:WORD_LSB];
        unused_low = ^bus_addr[WORD_LSB-1:0];
        hit_data   = (word_idx == IDX_W'(DATA_WORD));
        hit_csr    = (word_idx == IDX_W'(CSR_WORD));
        data_wr    = bus_valid &&  bus_write && hit_data;
        csr_wr     = bus_valid &&  bus_write && hit_csr;
        csr_rd     = bus_valid && !bus_write && hit_csr;
    end

endmodule

// File: rtl/prc_frame_track.sv
// Frame tracker: walks header, payload and check word, keeps the
// remaining payload count and the running XOR, and flags outcomes.
// Assumes word_acc only pulses while a load is in progress and never
// together with arm.
module prc_frame_track
    import prc_pkg::*;
#(
    parameter int                     DATA_W = 32,
    parameter int                     CNT_W  = 16,
    parameter logic [DATA_W-CNT_W-1:0] SYNC  = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              word_acc,
    input  logic [DATA_W-1:0] wdata,
    output prc_phase_e        phase,
    output logic              hdr_bad,
    output logic              sum_ok,
    output logic              sum_bad
);

    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    prc_phase_e        phase_q;
    logic [CNT_W-1:0]  left_q;
    logic [DATA_W-1:0] acc_q;
    logic [CNT_W-1:0]  hdr_cnt;
    logic              sync_match;

    // Split the incoming word into header fields.
    always_comb begin
        hdr_cnt    = wdata[CNT_W-1:0];
        sync_match = (wdata[DATA_W-1:CNT_W] == SYNC);
    end

    // Outcome flags for the word being accepted this cycle.
    always_comb begin
        hdr_bad = word_acc && (phase_q == PH_HDR)   && !sync_match;
        sum_ok  = word_acc && (phase_q == PH_CHECK) && (wdata == acc_q);
        sum_bad = word_acc && (phase_q == PH_CHECK) && (wdata != acc_q);
    end

    // Advance the frame position, count and checksum on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            left_q  <= CNT_ZERO;
            acc_q   <= '0;
        end else if (arm) begin
            phase_q <= PH_HDR;
            left_q  <= CNT_ZERO;
            acc_q   <= '0;
        end else if (word_acc) begin
            case (phase_q)
                PH_HDR: begin
                    if (!sync_match) begin
                        phase_q <= PH_OFF;
                    end else begin
                        left_q  <= hdr_cnt;
                        phase_q <= (hdr_cnt == CNT_ZERO) ? PH_CHECK : PH_PAYLOAD;
                    end
                end
                PH_PAYLOAD: begin
                    acc_q  <= acc_q ^ wdata;
                    left_q <= left_q - CNT_ONE;
                    if (left_q == CNT_ONE) begin
                        phase_q <= PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    phase_q <= PH_OFF;
                end
                default: begin
                    phase_q <= PH_OFF;
                end
            endcase
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/prc_status_reg.sv
// Status and start-bit register. Events are mutually exclusive because
// only one bus request completes per cycle.
module prc_status_reg
    import prc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        drop,
    input  logic        hdr_bad,
    input  logic        sum_bad,
    input  logic        sum_ok,
    input  logic        clear,
    output prc_status_e status,
    output logic        start
);

    prc_status_e status_q;
    logic        start_q;

    // Apply the single event of this cycle to status and start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_IDLE;
            start_q  <= 1'b0;
        end else if (arm) begin
            status_q <= ST_BUSY;
            start_q  <= 1'b1;
        end else if (drop) begin
            status_q <= ST_PRERR;
            start_q  <= 1'b0;
        end else if (hdr_bad) begin
            status_q <= ST_BADHDR;
            start_q  <= 1'b0;
        end else if (sum_bad) begin
            status_q <= ST_SUMERR;
            start_q  <= 1'b0;
        end else if (sum_ok) begin
            status_q <= ST_DONE;
            start_q  <= 1'b0;
        end else if (clear) begin
            status_q <= ST_IDLE;
            start_q  <= 1'b0;
        end
    end

    assign status = status_q;
    assign start  = start_q;

endmodule

// File: rtl/prc_ctrl.sv
// Partial reconfiguration loader front end (top).
// Takes a header/payload/check frame through a data port and forwards the
// payload to a valid/ready sink. Reports progress in a status field.
// Assumes the bus holds a write stable until bus_ready is high.
module prc_ctrl
    import prc_pkg::*;
#(
    parameter int                     ADDR_W = 4,
    parameter int                     DATA_W = 32,
    parameter int                     CNT_W  = 16,
    parameter logic [DATA_W-CNT_W-1:0] SYNC  = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data,
    input  logic              snk_ready
);

    localparam int PAD_W = DATA_W - STATUS_LSB - STATUS_W;

    logic        data_wr;
    logic        csr_wr;
    logic        csr_rd;
    logic        busy;
    logic        in_payload;
    logic        data_acc;
    logic        arm;
    logic        clear;
    logic        drop;
    logic        word_acc;
    logic        hdr_bad;
    logic        sum_ok;
    logic        sum_bad;
    prc_phase_e  phase_q;
    prc_status_e status_q;
    logic        start_q;
    logic [DATA_W-1:0] csr_word;

    prc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .data_wr   (data_wr),
        .csr_wr    (csr_wr),
        .csr_rd    (csr_rd)
    );

    // Handshake: only a payload write waits for the sink.
    always_comb begin
        busy       = (status_q == ST_BUSY);
        in_payload = busy && (phase_q == PH_PAYLOAD);
        bus_ready  = (data_wr && in_payload) ? snk_ready : 1'b1;
        snk_valid  = data_wr && in_payload;
        snk_data   = bus_wdata;
        data_acc   = data_wr && bus_ready;
        word_acc   = data_acc && busy;
        drop       = data_acc && !busy;
    end

    // Control-word writes: arm from idle, clear from any finished state.
    always_comb begin
        arm   = csr_wr &&  bus_wdata[START_BIT] && (status_q == ST_IDLE);
        clear = csr_wr && !bus_wdata[START_BIT] && !busy;
    end

    prc_frame_track #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC(SYNC)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .word_acc (word_acc),
        .wdata    (bus_wdata),
        .phase    (phase_q),
        .hdr_bad  (hdr_bad),
        .sum_ok   (sum_ok),
        .sum_bad  (sum_bad)
    );

    prc_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .drop    (drop),
        .hdr_bad (hdr_bad),
        .sum_bad (sum_bad),
        .sum_ok  (sum_ok),
        .clear   (clear),
        .status  (status_q),
        .start   (start_q)
    );

    // Read path: the control word, or zero for any other address.
    always_comb begin
        csr_word  = {{PAD_W{1'b0}}, status_q, 1'b0, start_q};
        bus_rdata = csr_rd ? csr_word : '0;
    end

endmodule

// File: rtl/prc_ctrl_chk.sv
// Property checker for prc_ctrl, attached by bind. It observes ports
// and the internal status, start and event signals.
module prc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       data_wr,
    input logic       csr_wr,
    input logic       wbit0,
    input logic       bus_ready,
    input logic       snk_valid,
    input logic       snk_ready,
    input logic       hdr_bad,
    input logic [2:0] status,
    input logic       start
);

    // R1: the first cycle after reset shows idle with start clear.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status == 3'd0 && !start));

    // R2: arming from idle gives in-progress with start set.
    a_r2_arm_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && wbit0 && status == 3'd0) |=> (status == 3'd4 && start));

    // R3: start reads 1 exactly while the load is in progress.
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start == (status == 3'd4));

    // R4: a bad sync pattern gives status 3.
    a_r4_bad_sync: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_bad |=> (status == 3'd3));

    // R6: the bus stalls while the sink is not ready.
    a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready) |-> !bus_ready);

    // R9: a data write outside a load is not forwarded.
    a_r9_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && status != 3'd4) |-> !snk_valid);

    // R9: and it sets status 1.
    a_r9_drop_err: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && status != 3'd4) |=> (status == 3'd1));

    // R10: clearing from a finished state returns to idle.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !wbit0 && status != 3'd4) |=> (status == 3'd0));

    // R7: only defined status codes appear.
    a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        status <= 3'd5);

endmodule

bind prc_ctrl prc_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (data_wr),
    .csr_wr    (csr_wr),
    .wbit0     (bus_wdata[0]),
    .bus_ready (bus_ready),
    .snk_valid (snk_valid),
    .snk_ready (snk_ready),
    .hdr_bad   (hdr_bad),
    .status    (status_q),
    .start     (start_q)
);

// File: tb/test_prc_ctrl.sv
module test_prc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_DATA = 4'h0;
    localparam logic [3:0] A_CSR  = 4'h4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        snk_valid;
    logic [31:0] snk_data;
    logic        snk_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;
    int stall_seen = 0;
    int cyc = 0;
    logic [31:0] exp_q[$];

    prc_ctrl i_prc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .snk_valid(snk_valid), .snk_data(snk_data),
        .snk_ready(snk_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Sink model: stalls on one cycle in three when stall_mode is set.
    always @(negedge clk) begin
        #1;
        cyc++;
        snk_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // Monitor: pop one expected word per accepted sink handshake (R5).
    always @(negedge clk) begin
        #3;
        if (rst_n && snk_valid && snk_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5/R9 unexpected sink word actual=%h expected=none", snk_data);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (snk_data !== e) begin
                    errors++;
                    $display("FAIL R5 sink word actual=%h expected=%h", snk_data, e);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic wr, input logic [3:0] addr, input logic [31:0] wd,
                            input bit fwd, output logic [31:0] rd);
        @(negedge clk); #2;
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_wdata = wd;
        forever begin
            #1;
            if (fwd && !snk_ready && bus_ready) begin
                errors++; checks++;
                $display("FAIL R6 bus_ready actual=1 expected=0 while sink stalled");
            end
            if (bus_ready) begin
                rd = bus_rdata;
                break;
            end
            stall_seen++;
            @(negedge clk); #2;
        end
        @(negedge clk); #2;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic csr_write(input logic [31:0] v);
        logic [31:0] rd;
        bus_xfer(1'b1, A_CSR, v, 1'b0, rd);
    endtask

    task automatic data_write(input logic [31:0] v, input bit fwd);
        logic [31:0] rd;
        if (fwd) exp_q.push_back(v);
        bus_xfer(1'b1, A_DATA, v, fwd, rd);
    endtask

    task automatic csr_check(input string req, input int st, input bit start);
        logic [31:0] rd;
        bus_xfer(1'b0, A_CSR, 32'h0, 1'b0, rd);
        check(req, rd, (32'(st) << 2) | 32'(start));
    endtask

    // Arm, send header, n payload words, then the check word.
    task automatic run_frame(input int n, input logic [31:0] seed, input logic [31:0] tail_mask,
                             input bit bad_sum, input int rearm_at);
        logic [31:0] sum;
        logic [31:0] w;
        sum = '0;
        csr_write(32'h1);
        csr_check("R2 armed", 4, 1'b1);
        data_write({16'hA5C3, 16'(n)}, 1'b0);
        for (int i = 0; i < n; i++) begin
            if (i == rearm_at) begin
                csr_write(32'h1);
                csr_check("R3 rearm ignored", 4, 1'b1);
            end
            w = seed ^ (32'h9E3779B9 * 32'(i + 1));
            if (i == n - 1) w = w & tail_mask;
            sum = sum ^ w;
            data_write(w, 1'b1);
        end
        data_write(bad_sum ? (sum ^ 32'h0000_0100) : sum, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        check("R1 snk_valid", {31'b0, snk_valid}, 32'h0);
        csr_check("R1 reset csr", 0, 1'b0);

        // R5 R7 R3: good frame with a one-byte tail and a mid-frame rearm
        run_frame(3, 32'h1234_5678, 32'h0000_00FF, 1'b0, 1);
        csr_check("R7 success", 5, 1'b0);
        check("R5 queue drained", 32'(exp_q.size()), 32'h0);

        // R10: start ignored when done, clear returns idle
        csr_write(32'h1);
        csr_check("R10 start ignored at done", 5, 1'b0);
        csr_write(32'h0);
        csr_check("R10 clear from done", 0, 1'b0);

        // R6: stalling sink, two-byte tail
        stall_mode = 1'b1;
        stall_seen = 0;
        run_frame(6, 32'hCAFE_0001, 32'h0000_FFFF, 1'b0, -1);
        stall_mode = 1'b0;
        csr_check("R6 success under stall", 5, 1'b0);
        check("R6 stall observed", 32'(stall_seen > 0), 32'h1);
        check("R6 no lost words", 32'(exp_q.size()), 32'h0);
        csr_write(32'h0);

        // R8 then R9: bad checksum, then a stray data write
        run_frame(2, 32'h0BAD_5EED, 32'h00FF_FFFF, 1'b1, -1);
        csr_check("R8 checksum error", 2, 1'b0);
        data_write(32'hDEAD_BEEF, 1'b0);
        csr_check("R9 drop after error", 1, 1'b0);
        csr_write(32'h0);
        csr_check("R10 clear from error", 0, 1'b0);

        // R4: wrong sync pattern, header not forwarded
        csr_write(32'h1);
        data_write(32'h1234_0002, 1'b0);
        csr_check("R4 bad header", 3, 1'b0);
        data_write(32'h0000_0001, 1'b0);
        csr_check("R9 drop after bad header", 1, 1'b0);
        csr_write(32'h0);

        // R9: data write while idle
        data_write(32'h5555_AAAA, 1'b0);
        csr_check("R9 drop while idle", 1, 1'b0);
        csr_write(32'h0);
        csr_check("R10 clear", 0, 1'b0);

        // R11: zero-count frame
        run_frame(0, 32'h0, 32'hFFFF_FFFF, 1'b0, -1);
        csr_check("R11 empty frame success", 5, 1'b0);
        check("R11 nothing forwarded", 32'(exp_q.size()), 32'h0);

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule